// File: doc/BRIEF.md
# Quadrature Encoder Timer Channel Pair

This block holds two 16-bit up/down timer channels that count the quadrature signals of a rotary or linear encoder. Channel 0 takes its phase pair from pins A and B, channel 1 from pins C and D. In phase-counting mode every edge on either phase moves the count by one. The relative order of the two phases sets the direction. Each channel keeps a compare register, a capture register with its own trigger input, a selectable counter-clear source, sticky status flags and an interrupt request.

Software programs a channel through a small register port with one write path and one read path. The setup order is: load the control register with the phase-counting mode and the wanted clear source, then set the channel's run bit. The prescaler and clock-edge fields of the control register can be written and read back, but they have no effect on counting. Status flags are cleared with a read-then-write-zero handshake, so a flag raised between the read and the write cannot be lost.

Register offsets (address bit 3 selects the channel): 0 control, 1 run, 2 count, 3 compare, 4 capture, 5 status, 6 interrupt enable. Control layout: bits [1:0] mode (2'b11 = phase counting), [4:2] prescaler field, [6:5] edge field, [8:7] clear source (00 none, 01 compare, 10 capture). Status layout: bit 0 compare match, bit 1 capture, bit 2 overflow, bit 3 underflow, bit 4 direction (1 = last step was down, read-only).

Top module: `qet_top`

## Requirements
- R1: After reset every register of both channels reads zero and both interrupt requests are low.
- R2: With the phase pair stepped through the states (A,B) = 00, 10, 11, 01 in that order (A leads B), each single-phase edge adds one to the count. The reverse order (B leads A) subtracts one per edge.
- R3: A change of both phases between two samples is ignored. The count does not move, and later single edges count normally from the new state.
- R4: An up step from 16'hFFFF gives 0 and sets status bit 2 (overflow).
- R5: A down step from 0 gives 16'hFFFF and sets status bit 3 (underflow).
- R6: Status bit 4 reads 0 after an up step and 1 after a down step.
- R7: The count changes only when the mode field is 2'b11 and the run bit is 1. Phase edges that arrive while the channel is inactive are never counted later.
- R8: In phase-counting mode, the values of the prescaler field (bits [4:2]) and the edge field (bits [6:5]) do not change the counting.
- R9: When a step makes the count equal to the compare register, status bit 0 is set. With clear source 01, the next step loads 0 instead of moving by one, and no overflow or underflow flag is set.
- R10: A rising edge on the channel's capture input, while the channel is active, copies the count into the capture register and sets status bit 1. With clear source 10, the count becomes 0 at the same time.
- R11: Writing 0 to a status bit clears it only if that bit was read as 1 since it was last cleared. A write of 0 without that read leaves the flag set, and a write of 1 never changes it.
- R12: irq[n] is high exactly while channel n has one of status bits [3:0] set together with the same bit of its interrupt-enable register.
- R13: Channel 0 counts only from pins A/B, and channel 1 counts only from pins C/D. Neither channel changes the other's state.
- R14: A phase edge presented before a rising clock edge shows in the count after the third rising edge, counting that edge as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Channel 0 phase A |
| pin_b | input | 1 | Channel 0 phase B |
| pin_c | input | 1 | Channel 1 phase A |
| pin_d | input | 1 | Channel 1 phase B |
| cap_in | input | 2 | Capture triggers, bit n for channel n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address: bit 3 channel, bits [2:0] offset |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Read strobe (arms status flags for clearing) |
| rd_addr | input | 4 | Read address: bit 3 channel, bits [2:0] offset |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq | output | 2 | Interrupt requests, bit n for channel n |

## Verification
The hardest cases to reach from the ports are the compare-triggered clear that is held back until the next step, and the wrap points at the ends of the 16-bit range. A plain stream of encoder edges would need tens of thousands of steps to reach either end. The stimulus therefore preloads the count through the register port to one or two steps short of each boundary, and then moves it with single Gray-code edges. For the compare clear, the bench walks the count onto the compare value and gives one more edge, which must land on zero with no wrap flag. The flag handshake is driven in both orders: a write of zero before any read, and then a write after a read.

// File: rtl/qet_pkg.sv
package qet_pkg;
  localparam int OFF_W = 3;

  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [OFF_W-1:0] OFF_RUN  = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CNT  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_CMP  = 3'd3;
  localparam logic [OFF_W-1:0] OFF_CAP  = 3'd4;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd5;
  localparam logic [OFF_W-1:0] OFF_IEN  = 3'd6;

  // sticky flag positions inside the status word
  localparam int N_FLAG = 4;
  localparam int FL_CMP = 0;
  localparam int FL_CAP = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;

  localparam logic [1:0] MODE_PHASE = 2'b11;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMP  = 2'b01,
    CLR_CAP  = 2'b10,
    CLR_RSVD = 2'b11
  } clr_src_e;

  typedef struct packed {
    clr_src_e   clr;
    logic [1:0] edge_sel;
    logic [2:0] psc;
    logic [1:0] mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/qet_sync.sv
module qet_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  always_comb begin
    st_d[0] = d;
    for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/qet_quad_dec.sv
module qet_quad_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_a,
  input  logic ph_b,
  output logic step_up,
  output logic step_dn
);
  logic a_q, b_q;
  logic one_chg, fwd;

  // exactly one phase moved since the last sample
  assign one_chg = (ph_a ^ a_q) ^ (ph_b ^ b_q);
  // new A differs from old B: A leads B
  assign fwd     = ph_a ^ b_q;

  assign step_up = one_chg & fwd;
  assign step_dn = one_chg & ~fwd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= ph_a;
      b_q <= ph_b;
    end
  end
endmodule

// File: rtl/qet_flags.sv
module qet_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] arm_q, arm_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr;
    assign clr = wr_hit & ~wr_bits[i] & arm_q[i];
    always_comb begin
      flag_d[i] = set[i] | (flag_q[i] & ~clr);
      arm_d[i]  = (arm_q[i] & flag_q[i] & ~clr) | (rd_hit & flag_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/qet_channel.sv
module qet_channel
  import qet_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph_a,
  input  logic             ph_b,
  input  logic             cap_trig,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [OFF_W-1:0] rd_off,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] cnt,
  output logic [N_FLAG:0]  stat,
  output logic             active,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] sync_q;
  logic       step_up, step_dn;
  logic       cap_prev_q;

  ctrl_t              ctrl_q, ctrl_d;
  logic               run_q, run_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   cmp_q, cmp_d;
  logic [CNT_W-1:0]   cap_q, cap_d;
  logic [N_FLAG-1:0]  ien_q, ien_d;
  logic               dir_q, dir_d;
  logic               pend_q, pend_d;

  logic wr_ctrl, wr_run, wr_cnt, wr_cmp, wr_cap, wr_stat, wr_ien, rd_stat;
  logic cap_ev, cap_clr, step;
  logic cmf_set, ovf_set, unf_set;
  logic [N_FLAG-1:0] flag_set, flags;

  qet_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cap_trig, ph_b, ph_a}),
    .q     (sync_q)
  );

  qet_quad_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph_a    (sync_q[0]),
    .ph_b    (sync_q[1]),
    .step_up (step_up),
    .step_dn (step_dn)
  );

  assign wr_ctrl = wr_en && (wr_off == OFF_CTRL);
  assign wr_run  = wr_en && (wr_off == OFF_RUN);
  assign wr_cnt  = wr_en && (wr_off == OFF_CNT);
  assign wr_cmp  = wr_en && (wr_off == OFF_CMP);
  assign wr_cap  = wr_en && (wr_off == OFF_CAP);
  assign wr_stat = wr_en && (wr_off == OFF_STAT);
  assign wr_ien  = wr_en && (wr_off == OFF_IEN);
  assign rd_stat = rd_en && (rd_off == OFF_STAT);

  // the prescaler and edge fields take no part in phase counting
  assign active  = run_q && (ctrl_q.mode == MODE_PHASE);
  assign cap_ev  = active && sync_q[2] && !cap_prev_q;
  assign cap_clr = cap_ev && (ctrl_q.clr == CLR_CAP);
  assign step    = active && (step_up || step_dn) && !wr_cnt && !cap_clr;

  always_comb begin
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    dir_d   = dir_q;
    cmf_set = 1'b0;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    if (wr_cnt) begin
      cnt_d  = wr_data;
      pend_d = 1'b0;
    end else if (cap_clr) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (step) begin
      dir_d = step_dn;
      if (pend_q) begin
        cnt_d  = '0;
        pend_d = 1'b0;
      end else begin
        if (step_up) begin
          cnt_d   = cnt_q + 1'b1;
          ovf_set = (cnt_q == CNT_MAX);
        end else begin
          cnt_d   = cnt_q - 1'b1;
          unf_set = (cnt_q == '0);
        end
        if (cnt_d == cmp_q) begin
          cmf_set = 1'b1;
          pend_d  = (ctrl_q.clr == CLR_CMP);
        end
      end
    end
  end

  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;
    run_d  = wr_run  ? wr_data[0] : run_q;
    cmp_d  = wr_cmp  ? wr_data : cmp_q;
    ien_d  = wr_ien  ? wr_data[N_FLAG-1:0] : ien_q;
    if (wr_cap)      cap_d = wr_data;
    else if (cap_ev) cap_d = cnt_q;
    else             cap_d = cap_q;
  end

  always_comb begin
    flag_set         = '0;
    flag_set[FL_CMP] = cmf_set;
    flag_set[FL_CAP] = cap_ev;
    flag_set[FL_OVF] = ovf_set;
    flag_set[FL_UNF] = unf_set;
  end

  qet_flags #(.N(N_FLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (flag_set),
    .rd_hit  (rd_stat),
    .wr_hit  (wr_stat),
    .wr_bits (wr_data[N_FLAG-1:0]),
    .flags   (flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      run_q      <= 1'b0;
      cnt_q      <= '0;
      cmp_q      <= '0;
      cap_q      <= '0;
      ien_q      <= '0;
      dir_q      <= 1'b0;
      pend_q     <= 1'b0;
      cap_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      run_q      <= run_d;
      cnt_q      <= cnt_d;
      cmp_q      <= cmp_d;
      cap_q      <= cap_d;
      ien_q      <= ien_d;
      dir_q      <= dir_d;
      pend_q     <= pend_d;
      cap_prev_q <= sync_q[2];
    end
  end

  always_comb begin
    case (rd_off)
      OFF_CTRL: rd_data = CNT_W'(ctrl_q);
      OFF_RUN:  rd_data = CNT_W'(run_q);
      OFF_CNT:  rd_data = cnt_q;
      OFF_CMP:  rd_data = cmp_q;
      OFF_CAP:  rd_data = cap_q;
      OFF_STAT: rd_data = CNT_W'({dir_q, flags});
      OFF_IEN:  rd_data = CNT_W'(ien_q);
      default:  rd_data = '0;
    endcase
  end

  assign cnt  = cnt_q;
  assign stat = {dir_q, flags};
  assign irq  = |(flags & ien_q);
endmodule

// File: rtl/qet_top.sv
module qet_top
  import qet_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             pin_c,
  input  logic             pin_d,
  input  logic [1:0]       cap_in,
  input  logic             wr_en,
  input  logic [OFF_W:0]   wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [OFF_W:0]   rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [1:0]       irq
);
  localparam int N_CH = 2;

  logic rst_meta_q, rst_core_q;
  logic [N_CH-1:0] ph_a_v, ph_b_v;

  logic [N_CH-1:0][CNT_W-1:0] ch_rd;
  logic [N_CH-1:0][CNT_W-1:0] ch_cnt;
  logic [N_CH-1:0][N_FLAG:0]  ch_stat;
  logic [N_CH-1:0]            ch_active;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_q <= rst_meta_q;
    end
  end

  assign ph_a_v = {pin_c, pin_a};
  assign ph_b_v = {pin_d, pin_b};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic sel_wr, sel_rd;
    assign sel_wr = wr_en && (wr_addr[OFF_W] == 1'(g));
    assign sel_rd = rd_en && (rd_addr[OFF_W] == 1'(g));

    qet_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_core_q),
      .ph_a     (ph_a_v[g]),
      .ph_b     (ph_b_v[g]),
      .cap_trig (cap_in[g]),
      .wr_en    (sel_wr),
      .wr_off   (wr_addr[OFF_W-1:0]),
      .wr_data  (wr_data),
      .rd_en    (sel_rd),
      .rd_off   (rd_addr[OFF_W-1:0]),
      .rd_data  (ch_rd[g]),
      .cnt      (ch_cnt[g]),
      .stat     (ch_stat[g]),
      .active   (ch_active[g]),
      .irq      (irq[g])
    );
  end

  assign rd_data = ch_rd[rd_addr[OFF_W]];
endmodule

// File: rtl/qet_top_chk.sv
module qet_top_chk #(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [1:0]            irq,
  input logic [1:0][CNT_W-1:0] ch_cnt,
  input logic [1:0][4:0]       ch_stat,
  input logic [1:0]            ch_active
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = ch_cnt[g] + 1'b1;

    a_r4_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_stat[g][2]) |-> ($past(ch_cnt[g]) == CNT_MAX && ch_cnt[g] == '0));

    a_r5_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_stat[g][3]) |-> ($past(ch_cnt[g]) == '0 && ch_cnt[g] == CNT_MAX));

    a_r6_down_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_stat[g][4]) |-> (cnt_inc == $past(ch_cnt[g]) || ch_cnt[g] == '0));

    a_r7_hold_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ch_active[g]) && !$past(wr_en)) |-> $stable(ch_cnt[g]));

    a_r12_irq_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[g]) |-> $past(wr_en));

    for (genvar k = 0; k < 4; k++) begin : g_flag
      a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ch_stat[g][k]) |-> $past(wr_en));
    end
  end
endmodule

bind qet_top qet_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .irq       (irq),
  .ch_cnt    (ch_cnt),
  .ch_stat   (ch_stat),
  .ch_active (ch_active)
);

// File: tb/qet_top_test.sv
module qet_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [2:0] O_CTRL = 3'd0, O_RUN = 3'd1, O_CNT = 3'd2,
                         O_CMP = 3'd3, O_CAP = 3'd4, O_STAT = 3'd5, O_IEN = 3'd6;

  logic clk, rst_n;
  logic pin_a, pin_b, pin_c, pin_d;
  logic [1:0] cap_in;
  logic wr_en, rd_en;
  logic [3:0] wr_addr, rd_addr;
  logic [W-1:0] wr_data, rd_data;
  logic [1:0] irq;

  qet_top #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c), .pin_d(pin_d),
    .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit         is_irq;
    logic [3:0] addr;
    logic [W-1:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  bit mon_busy = 1'b0;
  int n_chk = 0;
  int n_fail = 0;
  int idx [2];

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pops expected items and compares them against the outputs
  initial begin
    forever begin
      item_t it;
      @(negedge clk);
      if (sbq.size() > 0) begin
        mon_busy = 1'b1;
        it = sbq.pop_front();
        if (it.is_irq) begin
          #1 check(W'(irq), it.exp, it.tag);
        end else begin
          rd_addr = it.addr;
          rd_en   = 1'b1;
          #1 check(rd_data, it.exp, it.tag);
          @(posedge clk);
          #1 rd_en = 1'b0;
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic expect_reg(input bit ch, input logic [2:0] off, input logic [W-1:0] exp, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.addr = {ch, off}; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0 && !mon_busy);
  endtask

  task automatic expect_irq(input logic [1:0] exp, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.addr = '0; it.exp = W'(exp); it.tag = tag;
    sbq.push_back(it);
    wait (sbq.size() == 0 && !mon_busy);
  endtask

  task automatic wr(input bit ch, input logic [2:0] off, input logic [W-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {ch, off}; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Gray sequence on (A,B): 00, 10, 11, 01
  task automatic drive_pins(input int ch);
    logic a, b;
    a = (idx[ch] == 1) || (idx[ch] == 2);
    b = (idx[ch] >= 2);
    if (ch == 0) begin pin_a = a; pin_b = b; end
    else         begin pin_c = a; pin_d = b; end
  endtask

  task automatic move(input int ch, input int delta);
    @(negedge clk);
    idx[ch] = (idx[ch] + delta) % 4;
    drive_pins(ch);
    repeat (4) @(posedge clk);
  endtask

  task automatic fwd(input int ch);  move(ch, 1); endtask
  task automatic back(input int ch); move(ch, 3); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin_a = 0; pin_b = 0; pin_c = 0; pin_d = 0; cap_in = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0; rd_en = 0; rd_addr = '0;
    idx[0] = 0; idx[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset values
    expect_reg(0, O_CNT,  16'h0, "R1 count ch0");
    expect_reg(0, O_CTRL, 16'h0, "R1 ctrl ch0");
    expect_reg(0, O_STAT, 16'h0, "R1 stat ch0");
    expect_reg(1, O_CNT,  16'h0, "R1 count ch1");
    expect_irq(2'b00, "R1 irq");

    // R7 inactive channel ignores edges
    fwd(0);
    expect_reg(0, O_CNT, 16'h0, "R7 no mode, no run");
    wr(0, O_CMP, 16'h8000);
    wr(0, O_CTRL, 16'h0003);
    fwd(0); fwd(0);
    expect_reg(0, O_CNT, 16'h0, "R7 mode without run");
    wr(0, O_RUN, 16'h0001);
    repeat (4) @(posedge clk);
    expect_reg(0, O_CNT, 16'h0, "R7 stale edges not counted");

    // R14 latency of one step
    @(negedge clk);
    rd_addr = {1'b0, O_CNT};
    idx[0] = (idx[0] + 1) % 4;
    drive_pins(0);
    @(posedge clk); @(posedge clk);
    #1 check(rd_data, 16'h0, "R14 not yet after second edge");
    @(posedge clk);
    #1 check(rd_data, 16'h1, "R14 visible after third edge");

    // R2 / R6 direction
    fwd(0); fwd(0); fwd(0);
    expect_reg(0, O_CNT, 16'h4, "R2 up count");
    back(0); back(0);
    expect_reg(0, O_CNT, 16'h2, "R2 down count");
    expect_reg(0, O_STAT, 16'h10, "R6 dir down");
    fwd(0);
    expect_reg(0, O_STAT, 16'h00, "R6 dir up");

    // R3 double transition ignored
    move(0, 2);
    expect_reg(0, O_CNT, 16'h3, "R3 both phases changed");
    fwd(0);
    expect_reg(0, O_CNT, 16'h4, "R3 resumes");

    // R8 prescaler and edge fields have no effect
    wr(0, O_CTRL, 16'h0057);
    fwd(0);
    expect_reg(0, O_CNT, 16'h5, "R8 count with other fields");
    expect_reg(0, O_CTRL, 16'h0057, "R8 ctrl readback");

    // R5 underflow and R12 interrupt
    wr(0, O_CNT, 16'h0001);
    back(0);
    expect_reg(0, O_CNT, 16'h0, "R5 reach zero");
    back(0);
    expect_reg(0, O_CNT, 16'hFFFF, "R5 wrap value");
    expect_irq(2'b00, "R12 disabled");
    wr(0, O_IEN, 16'h0008);
    expect_irq(2'b01, "R12 underflow enabled");

    // R11 clear handshake (status not read yet)
    wr(0, O_STAT, 16'h0000);
    expect_reg(0, O_STAT, 16'h18, "R11 write without read");
    wr(0, O_STAT, 16'h0000);
    expect_reg(0, O_STAT, 16'h10, "R11 write after read");
    expect_irq(2'b00, "R12 flag cleared");

    // R4 overflow
    wr(0, O_CNT, 16'hFFFE);
    fwd(0);
    expect_reg(0, O_CNT, 16'hFFFF, "R4 at max");
    fwd(0);
    expect_reg(0, O_CNT, 16'h0, "R4 wrap value");
    expect_reg(0, O_STAT, 16'h04, "R4 overflow flag");
    wr(0, O_STAT, 16'h0004);
    expect_reg(0, O_STAT, 16'h04, "R11 write of one keeps flag");
    wr(0, O_STAT, 16'h0000);
    expect_reg(0, O_STAT, 16'h00, "R11 cleared");

    // R9 compare match with clear on compare
    wr(0, O_CTRL, 16'h0083);
    wr(0, O_CMP, 16'h0005);
    wr(0, O_CNT, 16'h0003);
    fwd(0);
    expect_reg(0, O_STAT, 16'h00, "R9 no match yet");
    fwd(0);
    expect_reg(0, O_CNT, 16'h5, "R9 at compare");
    expect_reg(0, O_STAT, 16'h01, "R9 match flag");
    fwd(0);
    expect_reg(0, O_CNT, 16'h0, "R9 cleared on next step");
    expect_reg(0, O_STAT, 16'h01, "R9 no wrap flag");
    fwd(0);
    expect_reg(0, O_CNT, 16'h1, "R9 counts after clear");

    // R10 capture with clear on capture
    wr(0, O_CTRL, 16'h0103);
    fwd(0);
    @(negedge clk) cap_in[0] = 1'b1;
    repeat (5) @(posedge clk);
    expect_reg(0, O_CAP, 16'h2, "R10 captured value");
    expect_reg(0, O_CNT, 16'h0, "R10 count cleared");
    expect_reg(0, O_STAT, 16'h03, "R10 capture flag");
    @(negedge clk) cap_in[0] = 1'b0;
    repeat (4) @(posedge clk);

    // R13 channel independence
    wr(1, O_CMP, 16'h0003);
    wr(1, O_CTRL, 16'h0003);
    wr(1, O_RUN, 16'h0001);
    fwd(1); fwd(1);
    expect_reg(1, O_CNT, 16'h2, "R13 ch1 counts C/D");
    expect_reg(0, O_CNT, 16'h0, "R13 ch0 untouched");
    fwd(0);
    expect_reg(0, O_CNT, 16'h1, "R13 ch0 counts A/B");
    expect_reg(1, O_CNT, 16'h2, "R13 ch1 untouched");
    wr(1, O_IEN, 16'h0001);
    fwd(1);
    expect_irq(2'b10, "R12 ch1 compare interrupt");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule